// File: doc/BRIEF.md
# Serial Boot Image Loader

This block pulls a program image off an asynchronous serial line and stores it, byte after byte, into an on-chip data RAM. The first byte goes to address zero. The line carries only data and no addresses, and the length of the image is not known in advance. The loader treats the image as finished when the line has stayed high for long enough, measured in bit times, after at least one frame has arrived.

At the end of the image, the two most recent bytes are read as a check word, high byte first. That word must equal the number of bytes received, counting the two check bytes, plus 0x100. An image that fills the RAM exactly therefore carries `RAM_BYTES + 0x100`, which is 0x2100 for the default 8 KB. If the word matches and no error was seen, the loader shuts its receiver down and gives a one-cycle request to start execution at address zero. Otherwise it raises an error flag. The CPU, the RAM array and any transmit path sit outside this block.

Top module: `sboot_loader`

## Requirements
- R1: Frames are 8N1. Each frame is a low start bit, then 8 data bits with the least-significant bit first, then a high stop bit, at `BAUD` derived from `CLK_HZ`. Every bit is sampled at 16x oversampling near its centre, and each received byte appears unchanged on `ram_wdata` with `ram_we` high for one cycle.
- R2: The k-th accepted byte (counting from 0) is written to `ram_addr` = k, so addresses run from 0 without gaps.
- R3: The image ends when the line stays high for more than `IDLE_BITS` bit times (24, about 1.25 ms at 19200 baud). Shorter gaps between bytes do not end it. At the end, `done` rises and then stays high until reset.
- R4: The idle timeout only starts counting after the first frame. A line that is idle before any data never raises `done`.
- R5: The last two bytes form a check word, earlier byte as the high byte. If it equals the byte count plus 0x100 and no error was seen, `ok`=1 and `err`=0, and `boot_go` pulses for exactly one cycle.
- R6: If the check word does not match, the result is `err`=1, `ok`=0 and no `boot_go` pulse. This includes an image of only one byte.
- R7: An image that fills the RAM exactly is accepted when its check word is `RAM_BYTES`+0x100.
- R8: Bytes beyond `RAM_BYTES` are not written. They set `err`, and the image is rejected.
- R9: A frame whose stop bit samples low writes nothing. It sets `err` at once, before the timeout, and the image is rejected. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: Once `done` is high, the receiver is off. Further frames cause no writes and leave `done`, `ok` and `err` unchanged.
- R11: While `en` is low, the line is ignored: nothing is written and the idle timeout does not run.
- R12: After reset, `ram_we`, `done`, `ok`, `err` and `boot_go` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Loader enable |
| rx | input | 1 | Serial receive line, idle high |
| ram_we | output | 1 | RAM write strobe, one cycle per stored byte |
| ram_addr | output | clog2(RAM_BYTES) | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| done | output | 1 | Image ended and result decided |
| ok | output | 1 | Check word matched and no error seen |
| err | output | 1 | Framing error, overflow or check mismatch |
| boot_go | output | 1 | One-cycle request to start execution at address 0 |

## Verification
A bad receive shift or a bad sampling point shows up as wrong bytes on the write port within one frame. An address counter that drifts or wraps shows up as a wrong write address on the very next byte. A byte counter that is off by one, or a check word assembled in the wrong order, is only visible at the end of the image: `ok` and `err` come out swapped about `IDLE_BITS` bit times after the last stop bit. A timeout that runs too early shows as `done` rising during a short gap between bytes. The bench therefore looks at `done` in the middle of gaps as well as at the end of each image.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

  localparam int OSR = 16;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rx_st_e;

  typedef enum logic {
    LD_LISTEN,
    LD_FINISH
  } ld_st_e;

endpackage

// File: rtl/sboot_tick.sv
module sboot_tick #(
  parameter int CLK_HZ = 12_000_000,
  parameter int BAUD   = 19_200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV_RAW = CLK_HZ / (BAUD * sboot_pkg::OSR);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sboot_rx.sv
module sboot_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       rx,
  output logic       line_hi,
  output logic       idle,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       frame_err
);
  import sboot_pkg::*;

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  logic          rx_m, rx_s;
  rx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          vld_q, vld_d, fe_q, fe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    fe_d  = 1'b0;
    if (!run) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!rx_s) st_d = RX_START;
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            sh_d  = {rx_s, sh_q[7:1]};
            if (bit_q == 3'd7) st_d = RX_STOP;
            else               bit_d = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            if (rx_s) begin
              vld_d = 1'b1;
              st_d  = RX_IDLE;
            end else begin
              fe_d  = 1'b1;
              st_d  = RX_WAITHI;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_WAITHI: begin
          if (rx_s) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
      fe_q  <= fe_d;
    end
  end

  assign line_hi   = rx_s;
  assign idle      = (st_q == RX_IDLE);
  assign byte_vld  = vld_q;
  assign byte_data = sh_q;
  assign frame_err = fe_q;

  // R1
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/sboot_ctrl.sv
module sboot_ctrl #(
  parameter int RAM_BYTES  = 8192,
  parameter int IDLE_BITS  = 24,
  parameter int CHK_OFFSET = 256,
  localparam int AW = $clog2(RAM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          line_hi,
  input  logic          rx_idle,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          frame_err,
  output logic          rx_run,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          done,
  output logic          ok,
  output logic          err,
  output logic          boot_go
);
  import sboot_pkg::*;

  localparam int IDLE_TICKS = IDLE_BITS * OSR;
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam logic [IW-1:0] IDLE_END = IW'(IDLE_TICKS);
  localparam logic [AW:0]   FULL     = (AW+1)'(RAM_BYTES);

  ld_st_e        st_q, st_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic [15:0]   tail_q, tail_d;
  logic [IW-1:0] idl_q, idl_d;
  logic          arm_q, arm_d;
  logic          we_q, we_d, go_q, go_d;
  logic          ok_q, ok_d, err_q, err_d, done_q, done_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    wd_q, wd_d;
  logic          match;

  assign rx_run = en && (st_q == LD_LISTEN);
  assign match  = (tail_q == (16'(cnt_q) + 16'(CHK_OFFSET)));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tail_d = tail_q;
    idl_d  = idl_q;
    arm_d  = arm_q;
    ok_d   = ok_q;
    err_d  = err_q;
    done_d = done_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    we_d   = 1'b0;
    go_d   = 1'b0;
    if (rx_run) begin
      if (frame_err) begin
        err_d = 1'b1;
        arm_d = 1'b1;
      end
      if (byte_vld) begin
        arm_d  = 1'b1;
        tail_d = {tail_q[7:0], byte_data};
        if (cnt_q < FULL) begin
          we_d   = 1'b1;
          addr_d = cnt_q[AW-1:0];
          wd_d   = byte_data;
          cnt_d  = cnt_q + 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
      if (arm_q && rx_idle && line_hi) begin
        if (tick) idl_d = idl_q + 1'b1;
      end else begin
        idl_d = '0;
      end
      if (idl_q == IDLE_END) begin
        st_d   = LD_FINISH;
        done_d = 1'b1;
        ok_d   = match && !err_q;
        err_d  = err_q || !match;
        go_d   = match && !err_q;
      end
    end else begin
      idl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_LISTEN;
      cnt_q  <= '0;
      tail_q <= '0;
      idl_q  <= '0;
      arm_q  <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
      idl_q  <= idl_d;
      arm_q  <= arm_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
      done_q <= done_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      we_q   <= we_d;
      go_q   <= go_d;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wd_q;
  assign done      = done_q;
  assign ok        = ok_q;
  assign err       = err_q;
  assign boot_go   = go_q;

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R6
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));
  // R5
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_go |=> !boot_go);
  // R10
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ram_we);
endmodule

// File: rtl/sboot_loader.sv
module sboot_loader #(
  parameter int CLK_HZ     = 12_000_000,
  parameter int BAUD       = 19_200,
  parameter int RAM_BYTES  = 8192,
  parameter int IDLE_BITS  = 24,
  parameter int CHK_OFFSET = 256
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         en,
  input  logic                         rx,
  output logic                         ram_we,
  output logic [$clog2(RAM_BYTES)-1:0] ram_addr,
  output logic [7:0]                   ram_wdata,
  output logic                         done,
  output logic                         ok,
  output logic                         err,
  output logic                         boot_go
);
  logic       rst_m, rst_n;
  logic       tick, line_hi, rx_idle, byte_vld, frame_err, rx_run;
  logic [7:0] byte_data;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_m <= 1'b0;
      rst_n <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_n <= rst_m;
    end
  end

  sboot_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick)
  );

  sboot_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (rx_run),
    .rx        (rx),
    .line_hi   (line_hi),
    .idle      (rx_idle),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .frame_err (frame_err)
  );

  sboot_ctrl #(
    .RAM_BYTES (RAM_BYTES),
    .IDLE_BITS (IDLE_BITS),
    .CHK_OFFSET(CHK_OFFSET)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .line_hi   (line_hi),
    .rx_idle   (rx_idle),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .frame_err (frame_err),
    .rx_run    (rx_run),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .done      (done),
    .ok        (ok),
    .err       (err),
    .boot_go   (boot_go)
  );
endmodule

// File: tb/sboot_loader_bench.sv
`timescale 1ns/1ps
module sboot_loader_bench;
  localparam int CLK_HZ = 125_000_000;
  localparam int BAUD   = CLK_HZ / 64;
  localparam int RAMB   = 64;
  localparam int AW     = $clog2(RAMB);
  localparam int BITC   = 64;
  localparam int IDLEB  = 24;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0;
  logic          rx = 1'b1;
  logic          ram_we, done, ok, err, boot_go;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;

  int checks = 0, fails = 0;
  int wr_cnt = 0, go_cnt = 0, addr_bad = 0;
  logic [7:0] mem [RAMB];
  logic [7:0] img [80];

  always #4 clk = ~clk;

  sboot_loader #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .RAM_BYTES(RAMB),
                 .IDLE_BITS(IDLEB), .CHK_OFFSET(256)) u_sboot_loader (
    .clk(clk), .rst_ni(rst_ni), .en(en), .rx(rx),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .done(done), .ok(ok), .err(err), .boot_go(boot_go)
  );

  always @(negedge clk) begin
    if (rst_ni && ram_we) begin
      if (int'(ram_addr) != wr_cnt) addr_bad++;
      mem[ram_addr] = ram_wdata;
      wr_cnt++;
    end
    if (rst_ni && boot_go) go_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; en = 1'b0; rx = 1'b1;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    wr_cnt = 0; go_cnt = 0; addr_bad = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop_bit);
    rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BITC) @(negedge clk);
    end
    rx = stop_bit;
    repeat (BITC) @(negedge clk);
    rx = 1'b1;
  endtask

  function automatic int chk_word(input int n);
    return n + 256;
  endfunction

  task automatic build(input int n, input bit good);
    int w;
    for (int i = 0; i < n; i++) img[i] = 8'($urandom);
    w = chk_word(n);
    if (!good) w = w ^ 1;
    if (n >= 2) begin
      img[n-2] = 8'(w >> 8);
      img[n-1] = 8'(w);
    end
  endtask

  task automatic send_img(input int n, input int gap_at);
    for (int i = 0; i < n; i++) begin
      send_byte(img[i], 1'b1);
      if (i == gap_at) repeat (10 * BITC) @(negedge clk);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic int mem_mismatch(input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (mem[i] != img[i]) m++;
    return m;
  endfunction

  initial begin
    repeat (190_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));

    // R12: reset state
    do_reset();
    check("R12 ram_we", int'(ram_we), 0);
    check("R12 flags", int'({done, ok, err, boot_go}), 0);

    // R4: idle line before data never ends image
    en = 1'b1;
    repeat (3000) @(negedge clk);
    check("R4 done before data", int'(done), 0);

    // R11: line ignored while disabled
    en = 1'b0;
    send_byte(8'hA5, 1'b1);
    send_byte(8'h3C, 1'b1);
    repeat (3000) @(negedge clk);
    check("R11 writes while disabled", wr_cnt, 0);
    check("R11 done while disabled", int'(done), 0);

    // R1 R2 R3 R5: 22-byte image with a short mid-image gap
    en = 1'b1;
    build(22, 1'b1);
    for (int i = 0; i < 22; i++) begin
      send_byte(img[i], 1'b1);
      if (i == 9) begin
        repeat (10 * BITC) @(negedge clk);
        check("R3 done during short gap", int'(done), 0);
      end
    end
    wait_done();
    check("R1 data bytes", mem_mismatch(22), 0);
    check("R2 write count", wr_cnt, 22);
    check("R2 address order", addr_bad, 0);
    check("R3 done", int'(done), 1);
    check("R5 ok/err", int'({ok, err}), 2);
    check("R5 boot_go pulses", go_cnt, 1);

    // R10: receiver off after done
    send_byte(8'h11, 1'b1);
    send_byte(8'h22, 1'b0);
    repeat (2000) @(negedge clk);
    check("R10 writes after done", wr_cnt, 22);
    check("R10 flags after done", int'({done, ok, err}), 6);
    check("R10 boot_go pulses", go_cnt, 1);

    // R6: corrupted check word
    do_reset(); en = 1'b1;
    n = 5 + int'($urandom % 12);
    build(n, 1'b0);
    send_img(n, -1);
    wait_done();
    check("R6 done", int'(done), 1);
    check("R6 ok/err", int'({ok, err}), 1);
    check("R6 boot_go", go_cnt, 0);

    // R6: single-byte image
    do_reset(); en = 1'b1;
    send_byte(8'h01, 1'b1);
    wait_done();
    check("R6 single byte ok/err", int'({done, ok, err}), 5);

    // R9: framing error
    do_reset(); en = 1'b1;
    build(6, 1'b1);
    send_byte(img[0], 1'b1);
    send_byte(img[1], 1'b1);
    send_byte(8'h5A, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 err immediate", int'(err), 1);
    check("R9 done not yet", int'(done), 0);
    check("R9 no write for bad frame", wr_cnt, 2);
    for (int i = 2; i < 6; i++) send_byte(img[i], 1'b1);
    wait_done();
    check("R9 final ok/err", int'({done, ok, err}), 5);
    check("R9 boot_go", go_cnt, 0);

    // R7: image fills RAM exactly
    do_reset(); en = 1'b1;
    build(RAMB, 1'b1);
    send_img(RAMB, -1);
    wait_done();
    check("R7 writes", wr_cnt, RAMB);
    check("R7 data", mem_mismatch(RAMB), 0);
    check("R7 ok/err", int'({done, ok, err}), 6);

    // R8: overflow
    do_reset(); en = 1'b1;
    build(RAMB + 2, 1'b1);
    send_img(RAMB + 2, -1);
    wait_done();
    check("R8 writes capped", wr_cnt, RAMB);
    check("R8 data kept", mem_mismatch(RAMB), 0);
    check("R8 ok/err", int'({done, ok, err}), 5);
    check("R8 boot_go", go_cnt, 0);

    // R5: random valid lengths
    for (int k = 0; k < 2; k++) begin
      do_reset(); en = 1'b1;
      n = 3 + int'($urandom % 14);
      build(n, 1'b1);
      send_img(n, int'($urandom % n));
      wait_done();
      check("R1 random data", mem_mismatch(n), 0);
      check("R5 random ok/err", int'({done, ok, err}), 6);
      check("R5 random boot_go", go_cnt, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule